// File: doc/BRIEF.md
# Single-Wire ROM Command Selector

This block is the network-layer controller of a single-wire bus slave that carries a fixed 64-bit registration number. A bit-level front-end handles the analog timing of the line. It reports each completed time slot and each bus reset to this block, and it drives the line during slots that this block marks as slave-transmit. After every bus reset the selector collects an 8-bit addressing command and runs it. The commands read out the registration number, match it against an address sent by the master, or take part in a tree search over the addresses on the bus. Other commands select the slave without any address, resume a previous selection, or switch the slave to the fast signalling rate.

When a command succeeds, the selector raises a select output. The function layer behind it then owns the bus until the next bus reset. The selector keeps two flags across resets. The resume flag records that this slave was the last one individually addressed. The overdrive flag tells the front-end to use the fast slot timing.

Top module: `sw_rom_selector`

## Requirements
- R1: After `rst_n` is released, `func_sel`, `tx_en`, `od_flag` and `rc_flag` are 0, and slot strobes are ignored until the first bus reset.
- R2: After a bus reset, the first 8 slots form a command byte, least significant bit first. The codes are 8'h33 read, 8'h55 match, 8'hF0 search, 8'hCC skip, 8'hA5 resume, 8'h3C fast-skip and 8'h69 fast-match.
- R3: The read command clears `rc_flag`. It then asserts `tx_en` for 64 slots and presents bit i of the registration number on `tx_bit` in slot i. Bits 7:0 are the family code, bits 55:8 the serial number and bits 63:56 the check byte. After slot 63, `func_sel` rises.
- R4: The match command clears `rc_flag` and compares 64 received bits, LSB first, against the registration number. If all bits match, `func_sel` and `rc_flag` go to 1. On the first mismatch the slave idles until a bus reset.
- R5: The search command clears `rc_flag`. For each bit index from 0, the slave sends the true bit, then the complement (both with `tx_en`), then reads the master's chosen bit. A chosen bit that differs makes the slave idle until reset. After 64 matching triplets, `func_sel` and `rc_flag` go to 1.
- R6: The skip command clears `rc_flag` and raises `func_sel`.
- R7: The resume command raises `func_sel` only if `rc_flag` is 1. Otherwise the slave idles until reset. It leaves `rc_flag` unchanged.
- R8: The fast-skip command sets `od_flag`, clears `rc_flag` and raises `func_sel`.
- R9: The fast-match command sets `od_flag` and clears `rc_flag` as soon as the command byte is complete. It then matches 64 bits as in R4. `od_flag` stays set on a mismatch.
- R10: A bus reset with `bus_rst_std` = 1 clears `od_flag`. A bus reset with `bus_rst_std` = 0 leaves it unchanged. Neither kind of reset changes `rc_flag`.
- R11: Any other command code makes the slave idle: no `tx_en` and no `func_sel` until the next bus reset, and `rc_flag` is unchanged.
- R12: A bus reset in any phase drops `func_sel` and `tx_en` and restarts command collection, even when it arrives together with a slot strobe.
- R13: All outputs are registered. They change only on the clock edge that samples a slot strobe or a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: the front-end saw a bus reset |
| bus_rst_std | input | 1 | Qualifies `bus_rst`: 1 = standard-length reset |
| slot_stb | input | 1 | One-cycle pulse: a time slot completed |
| slot_bit | input | 1 | Line value sampled in the completed slot |
| tx_en | output | 1 | The next slot is slave-transmit |
| tx_bit | output | 1 | Bit to drive in that slot (1 = release line) |
| func_sel | output | 1 | Function layer selected |
| od_flag | output | 1 | Fast slot timing in use |
| rc_flag | output | 1 | Resume flag |

## Verification
The bench builds the selector with a 64-bit registration number of 64'hC3_5A0F_96E1_7B24_28. It has ones and zeros in every field and both polarities at bit 0 and bit 63. This lets the read, match and search paths show an error at either end of the number or inside any byte. The bench uses the default 8-bit command width, so all seven code values are exercised. Random byte values cover the idle path for unknown codes. Random single-bit address errors at random positions cover the early-exit path of match, fast-match and search, including a drop-out at the last index.

// File: rtl/sw_rom_pkg.sv
package sw_rom_pkg;

    localparam logic [7:0] CODE_READ    = 8'h33;
    localparam logic [7:0] CODE_MATCH   = 8'h55;
    localparam logic [7:0] CODE_SEARCH  = 8'hF0;
    localparam logic [7:0] CODE_SKIP    = 8'hCC;
    localparam logic [7:0] CODE_RESUME  = 8'hA5;
    localparam logic [7:0] CODE_FSKIP   = 8'h3C;
    localparam logic [7:0] CODE_FMATCH  = 8'h69;

    typedef enum logic [3:0] {
        ST_WAIT,     // idle until bus reset
        ST_CMD,      // collecting command byte
        ST_READ,     // shifting registration number out
        ST_MATCH,    // comparing received address
        ST_SR_TRUE,  // search: send true bit
        ST_SR_CMPL,  // search: send complement
        ST_SR_PICK,  // search: read master choice
        ST_FUNC      // function layer selected
    } sel_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_READ,
        ACT_MATCH,
        ACT_SEARCH,
        ACT_SKIP,
        ACT_RESUME,
        ACT_FSKIP,
        ACT_FMATCH
    } rom_act_e;

endpackage

// File: rtl/sw_rom_cmd_decode.sv
module sw_rom_cmd_decode
    import sw_rom_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] code,
    output rom_act_e         act
);
    always_comb begin
        case (8'(code))
            CODE_READ:   act = ACT_READ;
            CODE_MATCH:  act = ACT_MATCH;
            CODE_SEARCH: act = ACT_SEARCH;
            CODE_SKIP:   act = ACT_SKIP;
            CODE_RESUME: act = ACT_RESUME;
            CODE_FSKIP:  act = ACT_FSKIP;
            CODE_FMATCH: act = ACT_FMATCH;
            default:     act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/sw_rom_id_mux.sv
module sw_rom_id_mux #(
    parameter int ID_W = 64,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic [ID_W-1:0]  id,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    logic [ID_W-1:0] hit;
    for (genvar g = 0; g < ID_W; g++) begin : g_sel
        assign hit[g] = (idx == IDX_W'(g)) & id[g];
    end
    assign bit_o = |hit;
endmodule

// File: rtl/sw_rom_selector.sv
module sw_rom_selector
    import sw_rom_pkg::*;
#(
    parameter int              ID_W   = 64,
    parameter int              CMD_W  = 8,
    parameter logic [ID_W-1:0] REG_ID = 64'hC35A0F96E17B2428
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    input  logic bus_rst_std,
    input  logic slot_stb,
    input  logic slot_bit,
    output logic tx_en,
    output logic tx_bit,
    output logic func_sel,
    output logic od_flag,
    output logic rc_flag
);
    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);

    typedef struct packed {
        sel_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] cmd;
        logic             od;
        logic             rc;
    } sel_regs_t;

    sel_regs_t  q, d;
    logic [CMD_W-1:0] cmd_full;
    rom_act_e   act;
    logic       id_bit;
    logic       last_bit;

    assign cmd_full = {slot_bit, q.cmd[CMD_W-1:1]};
    assign last_bit = (q.idx == LAST_ID);

    sw_rom_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .code (cmd_full),
        .act  (act)
    );

    sw_rom_id_mux #(.ID_W(ID_W)) u_mux (
        .id    (REG_ID),
        .idx   (q.idx),
        .bit_o (id_bit)
    );

    always_comb begin
        d = q;
        if (bus_rst) begin
            d.st  = ST_CMD;
            d.idx = '0;
            d.cmd = '0;
            if (bus_rst_std) d.od = 1'b0;
        end else if (slot_stb) begin
            case (q.st)
                ST_CMD: begin
                    d.cmd = cmd_full;
                    if (q.idx == LAST_CMD) begin
                        d.idx = '0;
                        case (act)
                            ACT_READ: begin
                                d.rc = 1'b0;
                                d.st = ST_READ;
                            end
                            ACT_MATCH: begin
                                d.rc = 1'b0;
                                d.st = ST_MATCH;
                            end
                            ACT_SEARCH: begin
                                d.rc = 1'b0;
                                d.st = ST_SR_TRUE;
                            end
                            ACT_SKIP: begin
                                d.rc = 1'b0;
                                d.st = ST_FUNC;
                            end
                            ACT_RESUME: begin
                                d.st = q.rc ? ST_FUNC : ST_WAIT;
                            end
                            ACT_FSKIP: begin
                                d.rc = 1'b0;
                                d.od = 1'b1;
                                d.st = ST_FUNC;
                            end
                            ACT_FMATCH: begin
                                d.rc = 1'b0;
                                d.od = 1'b1;
                                d.st = ST_MATCH;
                            end
                            default: d.st = ST_WAIT;
                        endcase
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_READ: begin
                    if (last_bit) d.st = ST_FUNC;
                    else          d.idx = q.idx + 1'b1;
                end
                ST_SR_TRUE: d.st = ST_SR_CMPL;
                ST_SR_CMPL: d.st = ST_SR_PICK;
                ST_MATCH, ST_SR_PICK: begin
                    if (slot_bit != id_bit) begin
                        d.st = ST_WAIT;
                    end else if (last_bit) begin
                        d.rc = 1'b1;
                        d.st = ST_FUNC;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        if (q.st == ST_SR_PICK) d.st = ST_SR_TRUE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_WAIT;
            q.idx <= '0;
            q.cmd <= '0;
            q.od  <= 1'b0;
            q.rc  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        tx_en  = (q.st == ST_READ) || (q.st == ST_SR_TRUE) || (q.st == ST_SR_CMPL);
        tx_bit = 1'b1;
        if (q.st == ST_READ || q.st == ST_SR_TRUE) tx_bit = id_bit;
        else if (q.st == ST_SR_CMPL)               tx_bit = ~id_bit;
    end

    assign func_sel = (q.st == ST_FUNC);
    assign od_flag  = q.od;
    assign rc_flag  = q.rc;

endmodule

// File: rtl/sw_rom_selector_chk.sv
module sw_rom_selector_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic bus_rst_std,
    input logic slot_stb,
    input logic tx_en,
    input logic func_sel,
    input logic od_flag,
    input logic rc_flag
);
    AST_STD_RESET_CLEARS_OD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst && bus_rst_std |=> !od_flag);                               // R10
    AST_SHORT_RESET_KEEPS_OD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst && !bus_rst_std |=> od_flag == $past(od_flag));             // R10
    AST_RESET_KEEPS_RC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> rc_flag == $past(rc_flag));                             // R10
    AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !func_sel && !tx_en);                                   // R12
    AST_NO_TX_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        func_sel |-> !tx_en);                                               // R3
    AST_RC_SET_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_flag) |-> $rose(func_sel));                                // R4
    AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb && !bus_rst |=> $stable(func_sel) && $stable(od_flag)
                                  && $stable(rc_flag) && $stable(tx_en));   // R13
endmodule

bind sw_rom_selector sw_rom_selector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst     (bus_rst),
    .bus_rst_std (bus_rst_std),
    .slot_stb    (slot_stb),
    .tx_en       (tx_en),
    .func_sel    (func_sel),
    .od_flag     (od_flag),
    .rc_flag     (rc_flag)
);

// File: tb/sw_rom_selector_tb.sv
module sw_rom_selector_tb;
    localparam logic [63:0] ID = 64'hC35A0F96E17B2428;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, bus_rst_std = 1'b0;
    logic slot_stb = 1'b0, slot_bit = 1'b1;
    logic tx_en, tx_bit, func_sel, od_flag, rc_flag;
    int   n_tests = 0, n_fail = 0;
    logic exp_od = 1'b0, exp_rc = 1'b0;

    always #2 clk = ~clk;

    sw_rom_selector #(.ID_W(64), .CMD_W(8), .REG_ID(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_rst_std(bus_rst_std),
        .slot_stb(slot_stb), .slot_bit(slot_bit), .tx_en(tx_en), .tx_bit(tx_bit),
        .func_sel(func_sel), .od_flag(od_flag), .rc_flag(rc_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_known(input logic [7:0] c);
        return c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC ||
               c == 8'hA5 || c == 8'h3C || c == 8'h69;
    endfunction

    task automatic slot(input logic b);
        @(negedge clk); slot_bit = b; slot_stb = 1'b1;
        @(negedge clk); slot_stb = 1'b0; slot_bit = 1'b1;
    endtask

    task automatic breset(input logic std);
        @(negedge clk); bus_rst = 1'b1; bus_rst_std = std;
        @(negedge clk); bus_rst = 1'b0; bus_rst_std = 1'b0;
        if (std) exp_od = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) slot(c[i]);
    endtask

    task automatic send_addr(input logic [63:0] a);
        for (int i = 0; i < 64; i++) begin
            slot(a[i]);
            if (a[i] != ID[i]) break;
        end
    endtask

    // read ROM: returns count of wrong transmitted bits
    task automatic do_read(output int bad);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (tx_en !== 1'b1 || tx_bit !== ID[i]) bad++;
            slot(tx_bit);
        end
    endtask

    task automatic do_search(input logic [63:0] pick, output int bad);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (tx_en !== 1'b1 || tx_bit !== ID[i]) bad++;
            slot(tx_bit);
            if (tx_en !== 1'b1 || tx_bit !== ~ID[i]) bad++;
            slot(tx_bit);
            if (tx_en !== 1'b0) bad++;
            slot(pick[i]);
            if (pick[i] != ID[i]) break;
        end
    endtask

    function automatic logic [63:0] flip_one(input int pos);
        return ID ^ (64'd1 << pos);
    endfunction

    task automatic run_random(input int iter);
        logic [7:0]  c;
        logic [63:0] a;
        int          bad;
        logic        exp_sel;
        breset($urandom % 2);
        case ($urandom % 8)
            0: c = 8'h33; 1: c = 8'h55; 2: c = 8'hF0; 3: c = 8'hCC;
            4: c = 8'hA5; 5: c = 8'h3C; 6: c = 8'h69;
            default: begin
                c = 8'($urandom);
                if (is_known(c)) c = 8'h00;
            end
        endcase
        a = ($urandom % 2) ? ID : flip_one($urandom % 64);
        send_cmd(c);
        exp_sel = 1'b0;
        case (c)
            8'h33: begin do_read(bad); check("R3 rnd read bits", 64'(bad), 0);
                         exp_rc = 1'b0; exp_sel = 1'b1; end
            8'h55: begin send_addr(a); exp_sel = (a == ID); exp_rc = exp_sel; end
            8'h69: begin exp_od = 1'b1; send_addr(a); exp_sel = (a == ID); exp_rc = exp_sel; end
            8'hF0: begin do_search(a, bad); check("R5 rnd search bits", 64'(bad), 0);
                         exp_sel = (a == ID); exp_rc = exp_sel; end
            8'hCC: begin exp_rc = 1'b0; exp_sel = 1'b1; end
            8'hA5: exp_sel = exp_rc;
            8'h3C: begin exp_od = 1'b1; exp_rc = 1'b0; exp_sel = 1'b1; end
            default: begin
                slot(1'b0); slot(1'b1);
                check("R11 unknown no tx", {63'd0, tx_en}, 0);
            end
        endcase
        check($sformatf("R2 rnd %0d cmd %0h sel", iter, c), {63'd0, func_sel}, {63'd0, exp_sel});
        check($sformatf("R10 rnd %0d od", iter), {63'd0, od_flag}, {63'd0, exp_od});
        check($sformatf("R4 rnd %0d rc", iter), {63'd0, rc_flag}, {63'd0, exp_rc});
    endtask

    initial begin : watchdog
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int bad;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", {60'd0, func_sel, tx_en, od_flag, rc_flag}, 0);
        send_cmd(8'hCC);
        check("R1 slots ignored before bus reset", {63'd0, func_sel}, 0);

        // R6 skip
        breset(1'b1); send_cmd(8'hCC);
        check("R6 skip selects", {62'd0, func_sel, rc_flag}, 64'b10);

        // R3 read
        breset(1'b1); send_cmd(8'h33);
        do_read(bad);
        check("R3 read bits LSB first", 64'(bad), 0);
        check("R3 read then select", {62'd0, func_sel, tx_en}, 64'b10);

        // R7 resume with rc=0
        breset(1'b1); send_cmd(8'hA5);
        check("R7 resume rc0 idles", {63'd0, func_sel}, 0);

        // R4 match success, then resume
        breset(1'b1); send_cmd(8'h55); send_addr(ID);
        check("R4 match selects", {62'd0, func_sel, rc_flag}, 64'b11);
        breset(1'b1);
        check("R10 reset keeps rc", {63'd0, rc_flag}, 1);
        send_cmd(8'hA5);
        check("R7 resume rc1 selects", {62'd0, func_sel, rc_flag}, 64'b11);

        // R4 match mismatch at last bit
        breset(1'b1); send_cmd(8'h55); send_addr(flip_one(63));
        check("R4 mismatch bit63 idles", {62'd0, func_sel, rc_flag}, 0);
        slot(1'b1);
        check("R4 stays idle", {62'd0, func_sel, tx_en}, 0);

        // R5 search success and dropout at bit 0
        breset(1'b1); send_cmd(8'hF0); do_search(ID, bad);
        check("R5 search triplets", 64'(bad), 0);
        check("R5 search selects", {62'd0, func_sel, rc_flag}, 64'b11);
        breset(1'b1); send_cmd(8'hF0); do_search(flip_one(0), bad);
        check("R5 dropout triplet", 64'(bad), 0);
        check("R5 dropout idle", {61'd0, func_sel, rc_flag, tx_en}, 0);

        // R8 fast-skip, R10 short reset keeps od
        breset(1'b1); send_cmd(8'h3C);
        check("R8 fast-skip", {61'd0, func_sel, od_flag, rc_flag}, 64'b110);
        breset(1'b0);
        check("R10 short reset keeps od", {63'd0, od_flag}, 1);
        breset(1'b1);
        check("R10 std reset clears od", {63'd0, od_flag}, 0);

        // R9 fast-match: od set right after command
        send_cmd(8'h69);
        check("R9 od after cmd byte", {62'd0, od_flag, func_sel}, 64'b10);
        send_addr(flip_one(17));
        check("R9 mismatch keeps od", {62'd0, od_flag, func_sel}, 64'b10);
        breset(1'b0); send_cmd(8'h69); send_addr(ID);
        check("R9 fast-match selects", {61'd0, func_sel, od_flag, rc_flag}, 64'b111);
        exp_od = 1'b1; exp_rc = 1'b1;

        // R11 unknown code
        breset(1'b1); send_cmd(8'h96);
        check("R11 unknown idles", {62'd0, func_sel, tx_en}, 0);
        check("R11 rc unchanged", {63'd0, rc_flag}, 1);

        // R12 reset mid read, with simultaneous strobe
        send_cmd(8'hCC);
        breset(1'b1); send_cmd(8'h33); slot(1'b1); slot(1'b1);
        @(negedge clk); bus_rst = 1'b1; bus_rst_std = 1'b1; slot_stb = 1'b1; slot_bit = 1'b0;
        @(negedge clk); bus_rst = 1'b0; slot_stb = 1'b0; slot_bit = 1'b1;
        check("R12 reset aborts read", {62'd0, tx_en, func_sel}, 0);
        send_cmd(8'hCC);
        check("R12 command after abort", {63'd0, func_sel}, 1);

        // R13 outputs hold without events
        repeat (5) @(negedge clk);
        check("R13 hold without events", {63'd0, func_sel}, 1);

        exp_od = 1'b0; exp_rc = 1'b0;
        for (int k = 0; k < 60; k++) run_random(k);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule